// File: doc/BRIEF.md
# Three-State Line Event Recorder

The recorder watches a group of serial-interface lines, each reported as low, high or undriven, together with a set of character receivers that present decoded bytes. Every change of a line's level, including a move into or out of the undriven state, and every received character becomes one event record. The record carries a timestamp taken in the cycle the event happened. Records from all sources go into one ordered FIFO, which a host-side reader drains through a valid/ready handshake at its own irregular pace.

The timestamp comes from a free-running counter. A prescaler advances it by one every `PRESCALE` clocks, so the tick can be set to match the clock period or a coarser unit such as a microsecond. A sync pulse clears both the counter and the prescaler on one edge, so several recorders wired to the same pulse share a timebase. When events arrive faster than the FIFO drains, records are dropped. The record written next after a drop carries an overflow marker.

Top module: `line_event_recorder`

## Requirements
- R1: Each line's level is decoded from the pair (`drv_hi_i`, `drv_lo_i`): 10 is high (state code 1), 01 is low (state code 0), and 00 or 11 is undriven (state code 2). Any change of the decoded state produces a record with `ev_is_char_o`=0, `ev_src_o`= the line index, and `ev_data_o`= the new state code.
- R2: No record is produced while a line keeps its decoded state, including a move between the two undriven encodings. After reset every line counts as undriven.
- R3: The timestamp counter advances by one every `PRESCALE` clocks after reset. A record's `ev_ts_o` equals the counter value during the cycle in which its input was presented.
- R4: A high `sync_i` at a clock edge sets both the counter and the prescaler to zero on that edge.
- R5: A pulse on `chr_valid_i[j]` produces a record with `ev_is_char_o`=1, `ev_src_o`=`N_LINES`+j, `ev_data_o`= the byte on `chr_data_i[8j+7:8j]`, and `ev_err_o`= `chr_err_i[j]`. Line records have `ev_err_o`=0.
- R6: Events presented in the same cycle leave in ascending source index and share one timestamp.
- R7: A record that meets a full FIFO is dropped. The next record written carries `ev_ovf_o`=1, and the records after it carry 0.
- R8: A new event on a source whose earlier record has not yet entered the FIFO is dropped. The next record written, which is that earlier record, carries `ev_ovf_o`=1.
- R9: `ev_valid_o` is low after reset. A presented record stays unchanged until `ev_ready_i` accepts it. Records leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Clears timestamp counter and prescaler |
| drv_hi_i | input | N_LINES | Line driven-high indication, one bit per line |
| drv_lo_i | input | N_LINES | Line driven-low indication, one bit per line |
| chr_valid_i | input | N_CHARS | Decoded character strobe per receiver |
| chr_data_i | input | 8*N_CHARS | Decoded character bytes |
| chr_err_i | input | N_CHARS | Receiver error flag, sampled with the strobe |
| ev_valid_o | output | 1 | A record is presented |
| ev_ready_i | input | 1 | Reader accepts the presented record |
| ev_ts_o | output | TS_W | Record timestamp |
| ev_is_char_o | output | 1 | 1 for a character record, 0 for a line record |
| ev_src_o | output | clog2(N_LINES+N_CHARS) | Source index |
| ev_data_o | output | 8 | Line state code or character byte |
| ev_err_o | output | 1 | Receiver error flag |
| ev_ovf_o | output | 1 | Records were dropped before this one |

## Verification
An event presented before rising edge E is captured at E. If it is the lowest pending source, it is written at E+1 and shows on the outputs after E+1. The k-th source of a same-cycle group appears k-1 edges later, and backpressure can delay any record further. So the bench does not compare results at fixed cycles. It pushes expected records into a queue at the falling edge where the stimulus is driven, takes the timestamp from its own model of the counter, which updates on rising edges, and pops one expected record for every handshake it sees at a falling edge. Drops are predicted from the known FIFO depth and the one-record-per-cycle write rate, and the marker is placed on the record due next.

// File: rtl/lev_pkg.sv
package lev_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    LS_LOW      = 2'd0,
    LS_HIGH     = 2'd1,
    LS_UNDRIVEN = 2'd2
  } lvl_e;

  function automatic lvl_e classify(input logic hi, input logic lo);
    case ({hi, lo})
      2'b10:   return LS_HIGH;
      2'b01:   return LS_LOW;
      default: return LS_UNDRIVEN;
    endcase
  endfunction
endpackage

// File: rtl/lev_timebase.sv
module lev_timebase #(
  parameter int TS_W     = 16,
  parameter int PRESCALE = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  output logic [TS_W-1:0] ts_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]   pre_q;
  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ts_q  <= '0;
    end else if (sync_i) begin
      pre_q <= '0;
      ts_q  <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      ts_q  <= ts_q + TS_W'(1);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  assign ts_o = ts_q;

  a_r4_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (ts_o == '0));

  a_r3_ts_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && ts_o != '1) |=> (ts_o == $past(ts_o) || ts_o == $past(ts_o) + TS_W'(1)));
endmodule

// File: rtl/lev_capture.sv
module lev_capture
  import lev_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_CHARS = 2,
  parameter int TS_W    = 16,
  localparam int N_SRC  = N_LINES + N_CHARS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_LINES-1:0]            drv_hi_i,
  input  logic [N_LINES-1:0]            drv_lo_i,
  input  logic [N_CHARS-1:0]            chr_valid_i,
  input  logic [N_CHARS*CHAR_W-1:0]     chr_data_i,
  input  logic [N_CHARS-1:0]            chr_err_i,
  input  logic [TS_W-1:0]               ts_i,
  input  logic [N_SRC-1:0]              clr_i,
  output logic [N_SRC-1:0]              pend_o,
  output logic [N_SRC-1:0][TS_W-1:0]    slot_ts_o,
  output logic [N_SRC-1:0][CHAR_W-1:0]  slot_data_o,
  output logic [N_SRC-1:0]              slot_err_o,
  output logic                          coll_o
);
  logic [N_SRC-1:0]             ev;
  logic [N_SRC-1:0][CHAR_W-1:0] ev_data;
  logic [N_SRC-1:0]             ev_err;
  logic [N_SRC-1:0]             pend_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    lvl_e cur, prev_q;
    assign cur = classify(drv_hi_i[i], drv_lo_i[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= LS_UNDRIVEN;
      else         prev_q <= cur;
    end
    assign ev[i]      = (cur != prev_q);
    assign ev_data[i] = CHAR_W'(cur);
    assign ev_err[i]  = 1'b0;
  end

  for (genvar j = 0; j < N_CHARS; j++) begin : g_chr
    assign ev[N_LINES+j]      = chr_valid_i[j];
    assign ev_data[N_LINES+j] = chr_data_i[j*CHAR_W +: CHAR_W];
    assign ev_err[N_LINES+j]  = chr_err_i[j];
  end

  // one holding slot per source; a busy slot refuses a new event
  for (genvar k = 0; k < N_SRC; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[k]      <= 1'b0;
        slot_ts_o[k]   <= '0;
        slot_data_o[k] <= '0;
        slot_err_o[k]  <= 1'b0;
      end else if (ev[k] && (!pend_q[k] || clr_i[k])) begin
        pend_q[k]      <= 1'b1;
        slot_ts_o[k]   <= ts_i;
        slot_data_o[k] <= ev_data[k];
        slot_err_o[k]  <= ev_err[k];
      end else if (clr_i[k]) begin
        pend_q[k]      <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;
  assign coll_o = |(ev & pend_q & ~clr_i);

  a_r6_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i));

  a_r6_grant_only_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~pend_q) == '0);
endmodule

// File: rtl/lev_fifo.sv
module lev_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic         full_o,
  output logic         valid_o,
  output logic [W-1:0] rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_i) wp_q <= wp_q + (AW+1)'(1);
      if (rd_i) rp_q <= rp_q + (AW+1)'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wp_q[AW-1:0]] <= wdata_i;
  end

  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign valid_o = (wp_q != rp_q);
  assign rdata_o = mem[rp_q[AW-1:0]];

  a_r7_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_i) |=> full_o);

  a_r9_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_i) |=> (valid_o && $stable(rdata_o)));
endmodule

// File: rtl/line_event_recorder.sv
module line_event_recorder
  import lev_pkg::*;
#(
  parameter int N_LINES    = 4,
  parameter int N_CHARS    = 2,
  parameter int TS_W       = 16,
  parameter int PRESCALE   = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int N_SRC     = N_LINES + N_CHARS,
  localparam int SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_i,
  input  logic [N_LINES-1:0]        drv_hi_i,
  input  logic [N_LINES-1:0]        drv_lo_i,
  input  logic [N_CHARS-1:0]        chr_valid_i,
  input  logic [N_CHARS*CHAR_W-1:0] chr_data_i,
  input  logic [N_CHARS-1:0]        chr_err_i,
  output logic                      ev_valid_o,
  input  logic                      ev_ready_i,
  output logic [TS_W-1:0]           ev_ts_o,
  output logic                      ev_is_char_o,
  output logic [SRC_W-1:0]          ev_src_o,
  output logic [CHAR_W-1:0]         ev_data_o,
  output logic                      ev_err_o,
  output logic                      ev_ovf_o
);
  localparam int REC_W = TS_W + 1 + SRC_W + CHAR_W + 2;

  logic [TS_W-1:0]               ts;
  logic [N_SRC-1:0]              pend, grant;
  logic [N_SRC-1:0][TS_W-1:0]    slot_ts;
  logic [N_SRC-1:0][CHAR_W-1:0]  slot_data;
  logic [N_SRC-1:0]              slot_err;
  logic                          coll, full, any, wr, drop, ovf_q, found;
  logic [SRC_W-1:0]              sel;
  logic [REC_W-1:0]              wrec, rrec;

  lev_timebase #(.TS_W(TS_W), .PRESCALE(PRESCALE)) u_tb (
    .clk_i, .rst_ni, .sync_i, .ts_o(ts)
  );

  lev_capture #(.N_LINES(N_LINES), .N_CHARS(N_CHARS), .TS_W(TS_W)) u_cap (
    .clk_i, .rst_ni, .drv_hi_i, .drv_lo_i, .chr_valid_i, .chr_data_i, .chr_err_i,
    .ts_i(ts), .clr_i(grant), .pend_o(pend), .slot_ts_o(slot_ts),
    .slot_data_o(slot_data), .slot_err_o(slot_err), .coll_o(coll)
  );

  // lowest pending index wins
  always_comb begin
    grant = '0;
    sel   = '0;
    found = 1'b0;
    for (int k = 0; k < N_SRC; k++) begin
      if (pend[k] && !found) begin
        grant[k] = 1'b1;
        sel      = SRC_W'(k);
        found    = 1'b1;
      end
    end
  end

  assign any  = |pend;
  assign wr   = any & ~full;
  assign drop = any & full;

  assign wrec = {slot_ts[sel], (int'(sel) >= N_LINES), sel,
                 slot_data[sel], slot_err[sel], ovf_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= (ovf_q & ~wr) | drop | coll;
  end

  lev_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(wrec),
    .rd_i(ev_valid_o & ev_ready_i), .full_o(full),
    .valid_o(ev_valid_o), .rdata_o(rrec)
  );

  assign {ev_ts_o, ev_is_char_o, ev_src_o, ev_data_o, ev_err_o, ev_ovf_o} = rrec;

  a_r7_drop_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop || coll) |=> ovf_q);

  a_r7_marker_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !coll) |=> !ovf_q);

  a_r9_no_valid_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && !ev_ready_i) |=> ev_valid_o);
endmodule

// File: tb/line_event_recorder_test.sv
module line_event_recorder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4, NC = 2, TSW = 16, PRE = 4, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, ready = 1'b1;
  logic [NL-1:0] hi = '0, lo = '0;
  logic [NC-1:0] cv = '0, cerr = '0;
  logic [NC*8-1:0] cd = '0;
  logic valid, is_char, err, ovf;
  logic [TSW-1:0] ts;
  logic [2:0] src;
  logic [7:0] data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_event_recorder #(.N_LINES(NL), .N_CHARS(NC), .TS_W(TSW),
                        .PRESCALE(PRE), .FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .drv_hi_i(hi), .drv_lo_i(lo),
    .chr_valid_i(cv), .chr_data_i(cd), .chr_err_i(cerr),
    .ev_valid_o(valid), .ev_ready_i(ready), .ev_ts_o(ts), .ev_is_char_o(is_char),
    .ev_src_o(src), .ev_data_o(data), .ev_err_o(err), .ev_ovf_o(ovf)
  );

  // timebase model from R3/R4
  int m_ts = 0, m_pre = 0;
  always @(posedge clk) begin
    if (!rst_n || sync) begin m_ts <= 0; m_pre <= 0; end
    else if (m_pre == PRE-1) begin m_pre <= 0; m_ts <= (m_ts + 1) % (1 << TSW); end
    else m_pre <= m_pre + 1;
  end

  typedef struct packed {
    logic [TSW-1:0] ts; logic ch; logic [2:0] src; logic [7:0] d; logic err; logic ovf;
  } exp_t;
  exp_t q[$];
  string q_req[$];
  bit expect_en = 1, ovf_pending = 0;
  int lstate[NL];

  function automatic void push(bit ch, int s, int d, bit e, string req);
    exp_t it;
    if (!expect_en) begin ovf_pending = 1; return; end
    it.ts = TSW'(m_ts); it.ch = ch; it.src = 3'(s); it.d = 8'(d); it.err = e;
    it.ovf = ovf_pending; ovf_pending = 0;
    q.push_back(it); q_req.push_back(req);
  endfunction

  function automatic void stage_line(int i, bit h, bit l, string req);
    int ns;
    hi[i] = h; lo[i] = l;
    ns = (h && !l) ? 1 : ((!h && l) ? 0 : 2);
    if (ns != lstate[i]) push(0, i, ns, 0, req);
    lstate[i] = ns;
  endfunction

  function automatic void stage_chr(int j, int b, bit e, string req);
    cv[j] = 1'b1; cd[j*8 +: 8] = 8'(b); cerr[j] = e;
    push(1, NL + j, b, e, req);
  endfunction

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      cv = '0;
    end
  endtask

  task automatic set_ready(bit r);
    @(posedge clk); #1 ready = r;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && q.size() != 0; k++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected record: ts=%0d ch=%0d src=%0d d=%h err=%0d ovf=%0d, expected none",
                 ts, is_char, src, data, err, ovf);
      end else begin
        exp_t e; string r;
        e = q.pop_front(); r = q_req.pop_front();
        if ({ts, is_char, src, data, err, ovf} !== e) begin
          fails++;
          $display("FAIL %s record: ts=%0d ch=%0d src=%0d d=%h err=%0d ovf=%0d, expected ts=%0d ch=%0d src=%0d d=%h err=%0d ovf=%0d",
                   r, ts, is_char, src, data, err, ovf, e.ts, e.ch, e.src, e.d, e.err, e.ovf);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: run hung, actual still running, expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) lstate[i] = 2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    step(2);
    tests++;   // R9 reset state
    if (valid !== 1'b0) begin
      fails++; $display("FAIL R9 valid after reset: actual %b expected 0", valid);
    end

    // R1 / R2: three-state transitions on line 0 and line 1
    stage_line(0, 1, 0, "R1"); step(3);
    stage_line(0, 0, 1, "R1"); step(2);
    stage_line(0, 1, 1, "R1"); step(2);
    stage_line(0, 0, 0, "R2"); step(5);
    stage_line(0, 0, 1, "R1"); step(1);
    stage_line(1, 0, 1, "R1"); step(7);
    stage_line(1, 0, 0, "R3"); step(9);

    // R5: character records
    stage_chr(0, 8'hA5, 0, "R5"); step(2);
    stage_chr(1, 8'h3C, 1, "R5"); step(3);

    // R6: same-cycle group, staged in ascending index
    stage_line(2, 1, 0, "R6");
    stage_line(3, 0, 1, "R6");
    stage_chr(0, 8'h11, 1, "R6");
    stage_chr(1, 8'h7E, 0, "R6");
    step(6);

    // R4: sync clears timebase; next event stamped 0
    step(3);
    sync = 1'b1; step(1); sync = 1'b0;
    stage_line(1, 1, 0, "R4"); step(6);
    stage_line(1, 0, 1, "R4"); step(4);
    drain();

    // R8: line 1 busy behind line 0 when it changes again
    stage_line(0, 1, 0, "R8");
    stage_line(1, 1, 0, "R8"); step(1);
    expect_en = 0;
    stage_line(1, 0, 0, "R8"); step(1);
    expect_en = 1; ovf_pending = 0;
    begin exp_t t; t = q[q.size()-1]; t.ovf = 1'b1; q[q.size()-1] = t; end
    step(3);
    stage_line(3, 1, 0, "R8"); step(3);
    drain();

    // R7: FIFO overflow under backpressure
    set_ready(0);
    for (int k = 0; k < DEPTH + 2; k++) begin
      if (k >= DEPTH) expect_en = 0;
      stage_line(2, k[0], !k[0], "R7");
      step(2);
    end
    expect_en = 1;
    step(4);
    set_ready(1);
    drain();
    stage_chr(0, 8'h5A, 0, "R7"); step(2);
    stage_chr(1, 8'hC3, 0, "R7"); step(2);
    drain();
    step(5);

    tests++;   // R2 nothing left over, nothing extra
    if (q.size() != 0 || valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 end state: actual pending=%0d valid=%b expected pending=0 valid=0",
               q.size(), valid);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule